// File: doc/BRIEF.md
# Parameterized Tap-Mask Pseudo-Random Bit Generator

This block is a Fibonacci-style linear feedback shift register that produces a pseudo-random bit stream. On each enabled clock edge the register moves one place toward its most significant end. The freed bit 0 takes the exclusive-OR of every register bit selected by a tap mask. The register width and the tap mask are parameters. The mask follows a primitive polynomial: bit k-1 is set when the term x^k is present. For example, x^12+x^11+x^10+x^4+1 becomes 12'hE08 on a 12-bit register, and x^3+x+1 becomes 3'b101.

A synchronous reset loads a non-zero seed, which is all ones by default. A zero seed is replaced with all ones, so the register can never start in the all-zero lock-up state. The most significant register bit is the serial random output, and the whole register is also brought out. The default instance is 8 bits wide with mask 8'hB8 (x^8+x^6+x^5+x^4+1). It repeats after 255 steps.

Top module: `lfsr_stream_gen`

## Requirements
- R1: A reset sampled high at a rising edge loads the seed (default all ones; a zero seed becomes all ones), visible on `state_o` right after that edge.
- R2: Reset takes priority over enable: with both high, the register loads the seed and does not step.
- R3: With reset and enable low, `state_o` keeps its value across clock edges.
- R4: With enable high and reset low, each edge gives next = {state[WIDTH-2:0], f}. Here f is the XOR of state[i] over every i where TAP_MASK[i] is 1, and bits with a 0 mask bit do not affect f.
- R5: `rand_bit_o` always equals state bit WIDTH-1.
- R6: After reset the state is never zero.
- R7: With the default 8-bit mask 8'hB8, the state first returns to the seed after exactly 255 enabled steps.
- R8: The first 10 serial output bits of the second period equal the first 10 of the first period.
- R9: A 3-bit instance with mask 3'b101 (x^3+x+1) returns to its seed after exactly 7 steps, following the same R4 rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high; loads the seed |
| enable_i | input | 1 | Advance one step per edge when high |
| rand_bit_o | output | 1 | Serial pseudo-random bit (state MSB) |
| state_o | output | WIDTH | Full register state |

## Verification
Every result in this block is due exactly one rising edge after the inputs that cause it: a seed load, a hold or a single step. There is no deeper pipeline. The bench changes inputs at a falling edge and lets one rising edge pass. It then checks state and serial bit at the next falling edge against an arithmetic model advanced by one step. Period length and the repeat of the first ten output bits are derived from a history of those per-step samples, indexed by the number of enabled edges since the seed was loaded.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int MAX_WIDTH = 64;
  typedef logic [MAX_WIDTH-1:0] wide_t;

  // Mask with the low w bits set.
  function automatic wide_t width_ones(input int w);
    wide_t m;
    for (int i = 0; i < MAX_WIDTH; i++) m[i] = (i < w);
    return m;
  endfunction

  // Number of polynomial terms (besides the constant) selected by a mask.
  function automatic int tap_count(input wide_t mask, input int w);
    int n;
    n = 0;
    for (int i = 0; i < MAX_WIDTH; i++) if (i < w && mask[i]) n++;
    return n;
  endfunction

  // Seed actually loaded: a zero seed is replaced with all ones.
  function automatic wide_t legal_seed(input wide_t seed, input int w);
    wide_t s;
    s = seed & width_ones(w);
    return (s == '0) ? width_ones(w) : s;
  endfunction
endpackage

// File: rtl/lfsr_tap_xor.sv
module lfsr_tap_xor #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o
);
  localparam int TAPS = lfsr_pkg::tap_count(lfsr_pkg::wide_t'(TAP_MASK), WIDTH);

  logic [WIDTH-1:0] tap_terms;

  // Only bits with a set mask bit feed the parity tree.
  for (genvar i = 0; i < WIDTH; i++) begin : g_term
    if (TAP_MASK[i]) begin : g_on
      assign tap_terms[i] = state_i[i];
    end else begin : g_off
      assign tap_terms[i] = 1'b0;
    end
  end

  if (TAPS == 0) begin : g_no_taps
    assign fb_o = 1'b0;
  end else begin : g_parity
    assign fb_o = ^tap_terms;
  end
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             enable_i,
  input  logic             fb_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic             load_seed;
  logic             advance;

  assign load_seed = rst_i;
  assign advance   = enable_i && !rst_i;

  always_ff @(posedge clk_i) begin
    if (load_seed)    state_q <= SEED;
    else if (advance) state_q <= {state_q[WIDTH-2:0], fb_i};
  end

  assign state_o = state_q;

  // Assertion support: becomes 1 once a reset has been seen.
  logic started_q = 1'b0;
  always_ff @(posedge clk_i) started_q <= started_q | rst_i;

  assert_seed_load_R1: assert property (@(posedge clk_i) disable iff (!started_q)
    load_seed |=> state_q == SEED);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!started_q)
    (!rst_i && !enable_i) |=> $stable(state_q));
  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!started_q)
    advance |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));
  assert_feedback_R4: assert property (@(posedge clk_i) disable iff (!started_q)
    advance |=> state_q[0] == $past(fb_i));
  assert_nonzero_R6: assert property (@(posedge clk_i) disable iff (!started_q)
    !rst_i |-> state_q != '0);
endmodule

// File: rtl/lfsr_stream_gen.sv
module lfsr_stream_gen #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0] SEED = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             enable_i,
  output logic             rand_bit_o,
  output logic [WIDTH-1:0] state_o
);
  localparam lfsr_pkg::wide_t SEED_WIDE =
    lfsr_pkg::legal_seed(lfsr_pkg::wide_t'(SEED), WIDTH);
  localparam logic [WIDTH-1:0] SEED_EFF = SEED_WIDE[WIDTH-1:0];

  logic [WIDTH-1:0] state_w;
  logic             fb_w;

  lfsr_tap_xor #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_taps (
    .state_i (state_w),
    .fb_o    (fb_w)
  );

  lfsr_state_reg #(.WIDTH(WIDTH), .SEED(SEED_EFF)) u_reg (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .enable_i (enable_i),
    .fb_i     (fb_w),
    .state_o  (state_w)
  );

  assign state_o    = state_w;
  assign rand_bit_o = state_w[WIDTH-1];
endmodule

// File: tb/lfsr_stream_gen_test.sv
`timescale 1ns/1ps
module lfsr_stream_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic en  = 1'b0;
  logic       bit8, bit3;
  logic [7:0] st8;
  logic [2:0] st3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lfsr_stream_gen uut (
    .clk_i(clk), .rst_i(rst), .enable_i(en), .rand_bit_o(bit8), .state_o(st8));

  lfsr_stream_gen #(.WIDTH(3), .TAP_MASK(3'b101), .SEED(3'b111)) uut_small (
    .clk_i(clk), .rst_i(rst), .enable_i(en), .rand_bit_o(bit3), .state_o(st3));

  // Reference step: shift toward MSB, bit 0 gets parity of masked bits.
  function automatic logic [7:0] ref_next(input logic [7:0] s, input logic [7:0] m, input int w);
    logic f;
    logic [7:0] ones;
    f = 1'b0;
    for (int i = 0; i < w; i++) if (m[i]) f = f ^ s[i];
    ones = 8'((1 << w) - 1);
    return ((s << 1) | {7'd0, f}) & ones;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [7:0] exp8;
  logic [2:0] exp3;
  logic       hist [0:265];
  int first8, first3;

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    tick(); tick();
    check("R1 reset seed 8b", st8, 8'hFF);
    check("R1 reset seed 3b", st3, 3'b111);
    check("R5 serial at seed", bit8, 1'b1);

    en = 1'b1;
    tick();
    check("R2 reset over enable", st8, 8'hFF);

    rst = 1'b0; en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R3 hold", st8, 8'hFF);
    end

    exp8 = 8'hFF; exp3 = 3'b111;
    first8 = -1; first3 = -1;
    hist[0] = bit8;
    en = 1'b1;
    for (int k = 1; k < 266; k++) begin
      exp8 = ref_next(exp8, 8'hB8, 8);
      exp3 = 3'(ref_next({5'd0, exp3}, 8'h05, 3));
      tick();
      check("R4 step 8b", st8, exp8);
      check("R9 step 3b", st3, exp3);
      check("R5 serial bit", bit8, st8[7]);
      checks++;
      if (st8 == 8'h00) begin
        errors++;
        $display("FAIL R6: actual %0h expected nonzero", st8);
      end
      hist[k] = bit8;
      if (first8 < 0 && st8 == 8'hFF) first8 = k;
      if (first3 < 0 && st3 == 3'b111) first3 = k;
    end
    check("R7 period 255", first8, 255);
    check("R9 period 7", first3, 7);
    for (int i = 0; i < 10; i++)
      check("R8 second period repeat", hist[255 + i], hist[i]);

    // Alternating enable: step on high, hold on low.
    for (int k = 0; k < 8; k++) begin
      en = k[0];
      if (en) exp8 = ref_next(exp8, 8'hB8, 8);
      tick();
      check(en ? "R4 step alt" : "R3 hold alt", st8, exp8);
    end

    // Mid-run reset with enable high.
    en = 1'b1; rst = 1'b1;
    tick();
    check("R1 R2 mid-run reset 8b", st8, 8'hFF);
    check("R1 mid-run reset 3b", st3, 3'b111);
    rst = 1'b0;
    tick();
    check("R4 first step after reset", st8, ref_next(8'hFF, 8'hB8, 8));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule